// File: doc/BRIEF.md
# Issue-Packet Register Dependence Checker

This block looks at a packet of instructions offered for issue in the same cycle and finds the first one that depends on an earlier instruction of that packet. Every slot brings a valid bit, two general-register source identifiers that can each be marked unused, a general-register destination with its own valid bit, a qualifying predicate source, and a predicate destination with a valid bit. Two separate comparator networks search for hazards. One is 7 bits wide and covers the general registers. The other is 6 bits wide and covers the predicate registers.

Issue logic sits in front of the execution ports and uses the block's two results. The issue mask marks the valid slots of the independent prefix of the packet. The blocked index names the first slot that has to wait, and the issue logic resends the packet from that slot on a later cycle. Both results are registered, so they appear one clock after the packet is presented.

Top module: `pkt_dep_check`

## Requirements
- R1: A valid slot is blocked by read-after-write when one of its used general sources equals the valid general destination of an earlier valid slot.
- R2: A valid slot is blocked by write-after-read when its valid general destination equals a used general source of an earlier valid slot.
- R3: A valid slot is blocked by write-after-write when its valid general destination equals the valid general destination of an earlier valid slot.
- R4: A slot that writes one of its own general sources, or that writes the predicate it reads, creates no dependence from that match alone.
- R5: Predicate identifiers (6 bits) receive the same three checks. The qualifying predicate counts as a source, and a predicate destination counts when its valid bit is set.
- R6: Predicate register 0 is always true. A qualifying predicate of 0 and a predicate destination of 0 never take part in a match.
- R7: When several slots are blocked, `blk_idx` reports the lowest-numbered one, and `issue_mask` bit k is set only for valid slots k below that index.
- R8: A match counts only when both sides are valid: the slot valid bits, the source-used bits and the destination valid bits. An invalid slot never blocks the packet and never issues.
- R9: Slot 0 is never blocked. When it is valid, `issue_mask[0]` is set.
- R10: When no slot is blocked, `blk_idx` equals SLOTS (6), and `issue_mask` equals `slot_vld`.
- R11: Outputs are registered and reflect the packet presented one clock earlier. A synchronous reset clears `issue_mask` to 0 and `blk_idx` to 0.

Field layout of the packed buses: slot k holds bits [k*W +: W] of each bus, where W is the field width. Valid vectors use bit k for slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | SLOTS | Slot holds an instruction |
| gsrc_a | input | SLOTS*GR_W | First general source per slot |
| gsrc_a_use | input | SLOTS | First source is read |
| gsrc_b | input | SLOTS*GR_W | Second general source per slot |
| gsrc_b_use | input | SLOTS | Second source is read |
| gdst | input | SLOTS*GR_W | General destination per slot |
| gdst_vld | input | SLOTS | General destination is written |
| qpred | input | SLOTS*PR_W | Qualifying predicate per slot |
| pdst | input | SLOTS*PR_W | Predicate destination per slot |
| pdst_vld | input | SLOTS | Predicate destination is written |
| issue_mask | output | SLOTS | Slots allowed to issue |
| blk_idx | output | IDX_W | First blocked slot, or SLOTS if none |

## Verification
The bench uses the default parameters: six slots, 7-bit general identifiers and 6-bit predicate identifiers. With these values the no-hazard index 6 can be reached, as can a hazard in the last slot. Each comparator network is exercised at its real width. Directed packets place one hazard kind at a chosen slot. A set of random packets draws register identifiers from a narrow range, which makes overlapping hazards common and tests the lowest-slot priority.

// File: rtl/pkt_dep_pkg.sv
package pkt_dep_pkg;

  // Hazard kinds found for one slot by one comparator network
  typedef struct packed {
    logic raw;
    logic war;
    logic waw;
  } hz_t;

endpackage

// File: rtl/pkt_dep_gr_net.sv
module pkt_dep_gr_net #(
  parameter int SLOTS = 6,
  parameter int ID_W  = 7
) (
  input  logic [SLOTS-1:0]      slot_vld,
  input  logic [SLOTS*ID_W-1:0] src_a,
  input  logic [SLOTS-1:0]      src_a_use,
  input  logic [SLOTS*ID_W-1:0] src_b,
  input  logic [SLOTS-1:0]      src_b_use,
  input  logic [SLOTS*ID_W-1:0] dst,
  input  logic [SLOTS-1:0]      dst_vld,
  output pkt_dep_pkg::hz_t [SLOTS-1:0] hz
);

  // Slot j is compared only against slots before it, so its own operands are exempt
  for (genvar j = 0; j < SLOTS; j++) begin : g_late
    logic [ID_W-1:0] my_a, my_b, my_d;
    assign my_a = src_a[j*ID_W +: ID_W];
    assign my_b = src_b[j*ID_W +: ID_W];
    assign my_d = dst[j*ID_W +: ID_W];

    always_comb begin
      hz[j] = '0;
      for (int i = 0; i < j; i++) begin
        if (slot_vld[i] && slot_vld[j]) begin
          if (dst_vld[i] &&
              ((src_a_use[j] && my_a == dst[i*ID_W +: ID_W]) ||
               (src_b_use[j] && my_b == dst[i*ID_W +: ID_W])))
            hz[j].raw = 1'b1;
          if (dst_vld[j] &&
              ((src_a_use[i] && my_d == src_a[i*ID_W +: ID_W]) ||
               (src_b_use[i] && my_d == src_b[i*ID_W +: ID_W])))
            hz[j].war = 1'b1;
          if (dst_vld[j] && dst_vld[i] && my_d == dst[i*ID_W +: ID_W])
            hz[j].waw = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pkt_dep_pr_net.sv
module pkt_dep_pr_net #(
  parameter int SLOTS = 6,
  parameter int ID_W  = 6
) (
  input  logic [SLOTS-1:0]      slot_vld,
  input  logic [SLOTS*ID_W-1:0] qp,
  input  logic [SLOTS*ID_W-1:0] pdst,
  input  logic [SLOTS-1:0]      pdst_vld,
  output pkt_dep_pkg::hz_t [SLOTS-1:0] hz
);

  // Predicate 0 is constant true: it is neither a real source nor a real target
  logic [SLOTS-1:0] qp_live, pd_live;

  for (genvar k = 0; k < SLOTS; k++) begin : g_live
    assign qp_live[k] = slot_vld[k] && (qp[k*ID_W +: ID_W] != '0);
    assign pd_live[k] = slot_vld[k] && pdst_vld[k] && (pdst[k*ID_W +: ID_W] != '0);
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_late
    logic [ID_W-1:0] my_q, my_p;
    assign my_q = qp[j*ID_W +: ID_W];
    assign my_p = pdst[j*ID_W +: ID_W];

    always_comb begin
      hz[j] = '0;
      for (int i = 0; i < j; i++) begin
        if (qp_live[j] && pd_live[i] && my_q == pdst[i*ID_W +: ID_W])
          hz[j].raw = 1'b1;
        if (pd_live[j] && qp_live[i] && my_p == qp[i*ID_W +: ID_W])
          hz[j].war = 1'b1;
        if (pd_live[j] && pd_live[i] && my_p == pdst[i*ID_W +: ID_W])
          hz[j].waw = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_dep_pick.sv
module pkt_dep_pick #(
  parameter int SLOTS = 6,
  parameter int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] slot_vld,
  input  logic [SLOTS-1:0] blocked,
  output logic [SLOTS-1:0] mask,
  output logic [IDX_W-1:0] idx
);

  logic [SLOTS-1:0] before_blk;

  // Lowest blocked slot wins; slots below it form the issue prefix
  always_comb begin
    idx        = IDX_W'(SLOTS);
    before_blk = '1;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (blocked[k]) begin
        idx        = IDX_W'(k);
        before_blk = '0;
        for (int m = 0; m < k; m++) before_blk[m] = 1'b1;
      end
    end
    mask = slot_vld & before_blk;
  end

endmodule

// File: rtl/pkt_dep_check.sv
module pkt_dep_check #(
  parameter int SLOTS = 6,
  parameter int GR_W  = 7,
  parameter int PR_W  = 6,
  parameter int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOTS-1:0]      slot_vld,
  input  logic [SLOTS*GR_W-1:0] gsrc_a,
  input  logic [SLOTS-1:0]      gsrc_a_use,
  input  logic [SLOTS*GR_W-1:0] gsrc_b,
  input  logic [SLOTS-1:0]      gsrc_b_use,
  input  logic [SLOTS*GR_W-1:0] gdst,
  input  logic [SLOTS-1:0]      gdst_vld,
  input  logic [SLOTS*PR_W-1:0] qpred,
  input  logic [SLOTS*PR_W-1:0] pdst,
  input  logic [SLOTS-1:0]      pdst_vld,
  output logic [SLOTS-1:0]      issue_mask,
  output logic [IDX_W-1:0]      blk_idx
);

  pkt_dep_pkg::hz_t [SLOTS-1:0] gr_hz, pr_hz;
  logic [SLOTS-1:0] blocked;
  logic [SLOTS-1:0] nxt_mask;
  logic [IDX_W-1:0] nxt_idx;
  logic             out_live;

  pkt_dep_gr_net #(.SLOTS(SLOTS), .ID_W(GR_W)) u_gr (
    .slot_vld  (slot_vld),
    .src_a     (gsrc_a),
    .src_a_use (gsrc_a_use),
    .src_b     (gsrc_b),
    .src_b_use (gsrc_b_use),
    .dst       (gdst),
    .dst_vld   (gdst_vld),
    .hz        (gr_hz)
  );

  pkt_dep_pr_net #(.SLOTS(SLOTS), .ID_W(PR_W)) u_pr (
    .slot_vld (slot_vld),
    .qp       (qpred),
    .pdst     (pdst),
    .pdst_vld (pdst_vld),
    .hz       (pr_hz)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_blk
    assign blocked[k] = (|gr_hz[k]) | (|pr_hz[k]);
  end

  pkt_dep_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pick (
    .slot_vld (slot_vld),
    .blocked  (blocked),
    .mask     (nxt_mask),
    .idx      (nxt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_mask <= '0;
      blk_idx    <= '0;
      out_live   <= 1'b0;
    end else begin
      issue_mask <= nxt_mask;
      blk_idx    <= nxt_idx;
      out_live   <= 1'b1;
    end
  end

  // R9: slot 0 has no predecessor, so it issues whenever valid
  a_r9_slot0_issues: assert property (@(posedge clk) disable iff (rst)
    out_live && $past(slot_vld[0]) |-> issue_mask[0]);

  // R8: no bit for an invalid slot
  a_r8_mask_in_valid: assert property (@(posedge clk) disable iff (rst)
    out_live |-> (issue_mask & ~$past(slot_vld)) == '0);

  // R7: no issue at or above the blocked slot
  a_r7_mask_below_idx: assert property (@(posedge clk) disable iff (rst)
    out_live |-> (issue_mask >> blk_idx) == '0);

  // R10: a clean packet issues every valid slot
  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    out_live && blk_idx == IDX_W'(SLOTS) |-> issue_mask == $past(slot_vld));

  // R7: index never exceeds packet capacity
  a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
    blk_idx <= IDX_W'(SLOTS));

  // R11: reported blocked slot was a valid slot of the previous packet
  a_r11_blk_was_valid: assert property (@(posedge clk) disable iff (rst)
    out_live && blk_idx < IDX_W'(SLOTS) |-> $past(slot_vld) != '0);

endmodule

// File: tb/pkt_dep_check_test.sv
module pkt_dep_check_test;

  localparam int S  = 6;
  localparam int GW = 7;
  localparam int PW = 6;
  localparam int IW = $clog2(S + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]    slot_vld, gsrc_a_use, gsrc_b_use, gdst_vld, pdst_vld;
  logic [S*GW-1:0] gsrc_a, gsrc_b, gdst;
  logic [S*PW-1:0] qpred, pdst;
  logic [S-1:0]    issue_mask;
  logic [IW-1:0]   blk_idx;

  always #5 clk = ~clk;

  pkt_dep_check #(.SLOTS(S), .GR_W(GW), .PR_W(PW)) uut (
    .clk(clk), .rst(rst), .slot_vld(slot_vld),
    .gsrc_a(gsrc_a), .gsrc_a_use(gsrc_a_use),
    .gsrc_b(gsrc_b), .gsrc_b_use(gsrc_b_use),
    .gdst(gdst), .gdst_vld(gdst_vld),
    .qpred(qpred), .pdst(pdst), .pdst_vld(pdst_vld),
    .issue_mask(issue_mask), .blk_idx(blk_idx)
  );

  // Bench-side packet description
  logic [GW-1:0] sa [S];
  logic [GW-1:0] sb [S];
  logic [GW-1:0] gd [S];
  logic [PW-1:0] qp [S];
  logic [PW-1:0] pd [S];
  logic v [S];
  logic sau [S];
  logic sbu [S];
  logic gdv [S];
  logic pdv [S];

  typedef struct {
    logic [S-1:0]  mask;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;

  task automatic check(input string tag, input logic [S-1:0] am, input logic [S-1:0] em,
                       input logic [IW-1:0] ai, input logic [IW-1:0] ei);
    n_checks++;
    if (am !== em || ai !== ei) begin
      n_errors++;
      $display("FAIL %s: mask=%b idx=%0d expected mask=%b idx=%0d", tag, am, ai, em, ei);
    end
  endtask

  // Default packet: all six slots valid, no register shared anywhere
  task automatic clean_packet();
    for (int k = 0; k < S; k++) begin
      v[k] = 1'b1; sau[k] = 1'b1; sbu[k] = 1'b1; gdv[k] = 1'b1; pdv[k] = 1'b0;
      sa[k] = GW'(10 + 3 * k); sb[k] = GW'(11 + 3 * k); gd[k] = GW'(60 + k);
      qp[k] = PW'(1 + k); pd[k] = PW'(20 + k);
    end
  endtask

  // Reference: stated hazard rules applied pairwise in program order
  function automatic logic hazard_at(int j);
    logic h = 1'b0;
    if (!v[j]) return 1'b0;
    for (int i = 0; i < j; i++) begin
      if (v[i]) begin
        if (gdv[i] && ((sau[j] && sa[j] == gd[i]) || (sbu[j] && sb[j] == gd[i]))) h = 1'b1;
        if (gdv[j] && ((sau[i] && gd[j] == sa[i]) || (sbu[i] && gd[j] == sb[i]))) h = 1'b1;
        if (gdv[j] && gdv[i] && gd[j] == gd[i]) h = 1'b1;
        if (qp[j] != 0 && pdv[i] && pd[i] != 0 && qp[j] == pd[i]) h = 1'b1;
        if (pdv[j] && pd[j] != 0 && qp[i] != 0 && pd[j] == qp[i]) h = 1'b1;
        if (pdv[j] && pd[j] != 0 && pdv[i] && pd[j] == pd[i]) h = 1'b1;
      end
    end
    return h;
  endfunction

  // Driver: present packet at a falling edge and queue its expected result
  task automatic send(input string tag, input int want_idx = -1);
    exp_t e;
    int first = S;
    @(negedge clk);
    for (int k = 0; k < S; k++) begin
      slot_vld[k] = v[k]; gsrc_a_use[k] = sau[k]; gsrc_b_use[k] = sbu[k];
      gdst_vld[k] = gdv[k]; pdst_vld[k] = pdv[k];
      gsrc_a[k*GW +: GW] = sa[k]; gsrc_b[k*GW +: GW] = sb[k]; gdst[k*GW +: GW] = gd[k];
      qpred[k*PW +: PW] = qp[k]; pdst[k*PW +: PW] = pd[k];
    end
    for (int k = S - 1; k >= 0; k--) if (hazard_at(k)) first = k;
    // directed cases also state their hand-worked index
    if (want_idx >= 0 && want_idx != first) begin
      n_checks++; n_errors++;
      $display("FAIL %s: bench model idx=%0d expected idx=%0d", tag, first, want_idx);
    end
    e.idx = IW'(first);
    e.mask = '0;
    for (int k = 0; k < first; k++) e.mask[k] = v[k];
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: result appears one edge after the packet (R11)
  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, issue_mask, e.mask, blk_idx, e.idx);
    end
  end

  initial begin
    #2000000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    clean_packet();
    for (int k = 0; k < S; k++) begin
      slot_vld[k] = 1'b1; gsrc_a_use[k] = 1'b1; gsrc_b_use[k] = 1'b1;
      gdst_vld[k] = 1'b1; pdst_vld[k] = 1'b0;
    end
    gsrc_a = '1; gsrc_b = '1; gdst = '1; qpred = '0; pdst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", issue_mask, '0, blk_idx, '0);
    rst = 1'b0;

    clean_packet(); send("R10 clean packet", 6);
    clean_packet(); sa[3] = gd[1]; send("R1 gr raw slot3", 3);
    clean_packet(); sb[4] = gd[0]; send("R1 gr raw src_b slot4", 4);
    clean_packet(); gd[2] = sb[0]; send("R2 gr war slot2", 2);
    clean_packet(); gd[4] = gd[1]; send("R3 gr waw slot4", 4);
    clean_packet(); gd[5] = gd[0]; send("R3 gr waw slot5", 5);
    clean_packet(); gd[2] = sa[2]; send("R4 self write", 6);
    clean_packet(); pdv[3] = 1'b1; pd[3] = qp[3]; send("R4 self predicate", 6);
    clean_packet(); pdv[2] = 1'b1; qp[5] = pd[2]; send("R5 pred raw slot5", 5);
    clean_packet(); pdv[1] = 1'b1; pd[1] = qp[0]; send("R5 pred war slot1", 1);
    clean_packet(); pdv[0] = 1'b1; pdv[3] = 1'b1; pd[3] = pd[0]; send("R5 pred waw slot3", 3);
    clean_packet(); pdv[0] = 1'b1; pd[0] = '0; qp[4] = '0; send("R6 p0 raw ignored", 6);
    clean_packet(); pdv[1] = 1'b1; pdv[2] = 1'b1; pd[1] = '0; pd[2] = '0; send("R6 p0 waw ignored", 6);
    clean_packet(); qp[0] = '0; qp[2] = '0; pdv[3] = 1'b1; pd[3] = '0; send("R6 p0 war ignored", 6);
    clean_packet(); gd[4] = gd[0]; sa[2] = gd[1]; send("R7 lowest of two", 2);
    clean_packet(); v[1] = 1'b0; v[4] = 1'b0; sa[3] = gd[2]; send("R7 gap before block", 3);
    clean_packet(); v[1] = 1'b0; v[3] = 1'b0; sa[2] = gd[1]; gd[3] = gd[0]; send("R8 invalid slots", 6);
    clean_packet(); sau[3] = 1'b0; sa[3] = gd[1]; send("R8 unused source", 6);
    clean_packet(); gdv[1] = 1'b0; gd[1] = sa[4]; sb[3] = gd[1]; send("R8 unwritten dest", 6);
    clean_packet(); for (int k = 1; k < S; k++) v[k] = 1'b0; send("R9 slot0 alone", 6);
    clean_packet(); sa[1] = gd[0]; send("R9 slot0 issues before block", 1);
    clean_packet(); for (int k = 0; k < S; k++) v[k] = 1'b0; send("R10 empty packet", 6);

    // random packets over a narrow register range
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < S; k++) begin
        v[k] = ($urandom_range(0, 7) != 0);
        sau[k] = $urandom_range(0, 1); sbu[k] = $urandom_range(0, 1);
        gdv[k] = $urandom_range(0, 1); pdv[k] = $urandom_range(0, 1);
        sa[k] = GW'($urandom_range(1, 12)); sb[k] = GW'($urandom_range(1, 12));
        gd[k] = GW'($urandom_range(1, 12));
        qp[k] = PW'($urandom_range(0, 4)); pd[k] = PW'($urandom_range(0, 4));
      end
      send("R7 random packet");
    end

    repeat (4) @(posedge clk);
    #2;
    if (sb_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL R11 drain: pending=%0d expected=0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule